// File: doc/BRIEF.md
# Collision Signal Presence Detector

This block tells a network controller that a collision is happening. A transceiver reports a collision by sending a periodic signal of about 10 MHz on a collision line. The block samples that line, already turned into a logic level, with a fast clock. It raises a single collision flag while the periodic activity lasts. Activity is seen as a series of negative-going pulses. A pulse counts only when the line stays low for a minimum number of consecutive samples, so short glitches have no effect. One accepted pulse alone never raises the flag. A second accepted pulse must follow within a confirmation window.

Once the flag is up, every accepted pulse reloads a hold timer. The flag falls when that timer runs out, so release always comes a fixed time after the last activity. The timeout is chosen to meet the controller's release deadline. When loopback is requested, the collision line is ignored and the flag is held low.

The control is a three-state machine:
- IDLE: no activity.
- ARMED: one pulse has been accepted and the confirmation window is running.
- ACTIVE: the flag is high.

Its transitions are:
- FIRST (IDLE to ARMED): the first pulse is accepted.
- CONFIRM (ARMED to ACTIVE): the required number of pulses arrives inside the window.
- LAPSE (ARMED to IDLE): the window runs out first.
- RELOAD (ACTIVE to ACTIVE): a pulse restarts the hold timer.
- RELEASE (ACTIVE to IDLE): the hold timer expires with no new pulse.
- LOOP (any state to IDLE): loopback is high.

Top module: `col_presence_det`

## Requirements
- R1: While `rst_n` is low, and after it is released, `col_o` is 0 until activity is confirmed. An idle line is high.
- R2: The line goes low in cycle f and it is the second accepted pulse. Then `col_o` is 1 from cycle f+4. Each earlier cycle shows 0. Continued 10-cycle-period activity keeps `col_o` at 1.
- R3: A low level lasting fewer than `MIN_LOW` consecutive samples is not a pulse and never raises `col_o`. A low level lasting exactly `MIN_LOW` samples is accepted.
- R4: Two accepted pulses whose falling cycles are at most `WIN_CYC` apart raise `col_o`. Two pulses `WIN_CYC`+1 or more cycles apart do not.
- R5: The last accepted pulse falls in cycle f. Then `col_o` stays 1 through cycle f+3+`HOLD_CYC` and is 0 in cycle f+4+`HOLD_CYC`. It never falls earlier while `loop_i` is low.
- R6: In any cycle where `loop_i` is 1, `col_o` is 0 in that same cycle. Pulses on `col_i` during loopback are not counted.
- R7: After `loop_i` returns to 0, detection restarts from IDLE. `col_o` rises only after two new accepted pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_i | input | 1 | Collision line, logic level, idle high |
| loop_i | input | 1 | Loopback request, synchronous to `clk` |
| col_o | output | 1 | Collision flag to the controller |

## Verification
The bench builds the block with `MIN_LOW`=2, `WIN_CYC`=15, `HOLD_CYC`=30 and `EDGES_NEEDED`=2 on a 10 ns clock. At that clock a 10-cycle period stands for the 10 MHz collision signal, and the window and hold values keep the same proportions to that period as the defaults do. The small window puts both sides of the window edge within reach: pulses 15 cycles apart and pulses 16 cycles apart. The short hold lets the exact release cycle be checked after a burst in a few dozen cycles. With two samples as the minimum, one-sample glitches can be compared against pulses that are exactly two samples long.

// File: rtl/coldet_pkg.sv
package coldet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } coldet_state_e;

endpackage

// File: rtl/coldet_sync.sv
// Two-stage synchronizer for the collision line; resets to the idle (high) level.
module coldet_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            q_o    <= 1'b1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/coldet_lowqual.sv
// Accepts a negative-going pulse once the line has been low for MIN_LOW
// consecutive samples; emits one single-cycle strobe per low interval.
module coldet_lowqual #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic mask_i,
    output logic edge_o
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] CNT_SAT  = LW'(MIN_LOW);
    localparam logic [LW-1:0] CNT_FIRE = LW'(MIN_LOW - 1);

    logic          low_seen;
    logic [LW-1:0] low_cnt;

    assign low_seen = !line_i && !mask_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!low_seen) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_SAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign edge_o = low_seen && (low_cnt == CNT_FIRE);
endmodule

// File: rtl/coldet_timer.sv
// Reloadable down counter; reload wins over counting, stops at zero.
module coldet_timer #(
    parameter int SPAN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam int TW = $clog2(SPAN + 1);
    localparam logic [TW-1:0] RELOAD = TW'(SPAN - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/col_presence_det.sv
module col_presence_det #(
    parameter int MIN_LOW      = 2,
    parameter int WIN_CYC      = 30,
    parameter int HOLD_CYC     = 60,
    parameter int EDGES_NEEDED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_i,
    input  logic loop_i,
    output logic col_o
);
    import coldet_pkg::*;

    localparam int EW = $clog2(EDGES_NEEDED + 1);
    localparam logic [EW-1:0] EDGE_GOAL = EW'(EDGES_NEEDED);

    coldet_state_e state_q, state_d;
    logic          line_sync;
    logic          edge_ok;
    logic          win_zero;
    logic          hold_zero;
    logic          win_load;
    logic [EW-1:0] edge_cnt_q;
    logic [EW-1:0] edge_cnt_nx;

    coldet_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (col_i),
        .q_o   (line_sync)
    );

    coldet_lowqual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_sync),
        .mask_i (loop_i),
        .edge_o (edge_ok)
    );

    assign win_load = (state_q == ST_IDLE) && edge_ok && !loop_i;

    coldet_timer #(.SPAN(WIN_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (win_load),
        .zero_o (win_zero)
    );

    coldet_timer #(.SPAN(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (edge_ok),
        .zero_o (hold_zero)
    );

    assign edge_cnt_nx = edge_cnt_q + 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!loop_i && edge_ok) begin          // FIRST
                    state_d = (EDGES_NEEDED <= 1) ? ST_ACTIVE : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (loop_i) begin                      // LOOP
                    state_d = ST_IDLE;
                end else if (edge_ok) begin
                    if (edge_cnt_nx >= EDGE_GOAL) begin
                        state_d = ST_ACTIVE;           // CONFIRM
                    end
                end else if (win_zero) begin           // LAPSE
                    state_d = ST_IDLE;
                end
            end
            ST_ACTIVE: begin
                if (loop_i) begin                      // LOOP
                    state_d = ST_IDLE;
                end else if (hold_zero && !edge_ok) begin
                    state_d = ST_IDLE;                 // RELEASE
                end                                    // else RELOAD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pulses counted toward confirmation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (state_d != ST_ARMED) begin
            edge_cnt_q <= (state_d == ST_ACTIVE) ? EDGE_GOAL : '0;
        end else if (edge_ok && !loop_i) begin
            edge_cnt_q <= (state_q == ST_IDLE) ? EW'(1) : edge_cnt_nx;
        end
    end

    // Outputs
    always_comb begin
        col_o = (state_q == ST_ACTIVE) && !loop_i;
    end
endmodule

// File: rtl/coldet_chk.sv
module coldet_chk #(
    parameter int HOLD_CYC = 60
) (
    input logic clk,
    input logic rst_n,
    input logic loop_i,
    input logic col_o,
    input logic edge_ok
);
    localparam int SW = $clog2(HOLD_CYC + 2);
    localparam logic [SW-1:0] SINCE_MAX = SW'(HOLD_CYC + 1);
    localparam logic [SW-1:0] HOLD_V    = SW'(HOLD_CYC);

    logic [SW-1:0] since_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_edge <= SINCE_MAX;
        end else if (edge_ok) begin
            since_edge <= '0;
        end else if (since_edge != SINCE_MAX) begin
            since_edge <= since_edge + 1'b1;
        end
    end

    a_r6_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        loop_i |-> !col_o);

    a_r3_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_o) |-> $past(edge_ok));

    a_r5_release_bound: assert property (@(posedge clk) disable iff (!rst_n)
        col_o |-> (since_edge < HOLD_V));

    a_r5_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(col_o) && !loop_i) |-> (since_edge >= HOLD_V));

    a_r1_quiet_without_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (since_edge == SINCE_MAX) |-> !col_o);
endmodule

bind col_presence_det coldet_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_i  (loop_i),
    .col_o   (col_o),
    .edge_ok (edge_ok)
);

// File: tb/tb_col_presence_det.sv
module tb_col_presence_det;
    localparam int MIN_LOW = 2;
    localparam int WIN     = 15;
    localparam int HOLD    = 30;

    logic clk = 1'b0;
    logic rst_n;
    logic col_i;
    logic loop_i;
    logic col_o;

    always #5 clk = ~clk;

    col_presence_det #(
        .MIN_LOW(MIN_LOW), .WIN_CYC(WIN), .HOLD_CYC(HOLD), .EDGES_NEEDED(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .col_i(col_i), .loop_i(loop_i), .col_o(col_o)
    );

    typedef struct {
        int    at;
        bit    v;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expectations due this cycle and compares
    always @(posedge clk) begin
        #3;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            total++;
            if (it.at < cyc || col_o !== it.v) begin
                bad++;
                $display("FAIL %s at cycle %0d: col_o=%b expected %b", it.tag, it.at, col_o, it.v);
            end
        end
        if (cyc > 6000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(int at, bit v, string tag);
        exp_t it;
        it.at = at; it.v = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(bit line, bit lb);
        @(posedge clk);
        #1;
        col_i  = line;
        loop_i = lb;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    // Periodic activity: period 10 cycles, low for lowlen; loopback in [lb_a, lb_b)
    task automatic burst(int periods, int lowlen, int lb_a, int lb_b);
        for (int i = 0; i < periods * 10; i++)
            step(((i % 10) < lowlen) ? 1'b0 : 1'b1, (i >= lb_a && i < lb_b));
    endtask

    // Two valid pulses (3 cycles low) whose falls are s cycles apart
    task automatic pair(int s);
        for (int i = 0; i < s + 10; i++)
            step((i < 3 || (i >= s && i < s + 3)) ? 1'b0 : 1'b1, 1'b0);
    endtask

    initial begin
        int t0;
        col_i  = 1'b1;
        loop_i = 1'b0;
        rst_n  = 1'b0;
        idle(2);
        push(cyc + 1, 1'b0, "R1 in reset");
        push(cyc + 2, 1'b0, "R1 in reset");
        idle(3);
        rst_n = 1'b1;
        push(cyc + 3, 1'b0, "R1 after reset");
        idle(6);

        // R2 / R5: 10 MHz-like burst, 5-cycle lows
        t0 = cyc + 1;
        push(t0 + 13, 1'b0, "R2 one pulse not enough");
        push(t0 + 14, 1'b1, "R2 rise");
        push(t0 + 50, 1'b1, "R2 held during activity");
        push(t0 + 73 + HOLD, 1'b1, "R5 still high");
        push(t0 + 74 + HOLD, 1'b0, "R5 release");
        burst(8, 5, -1, -1);
        idle(HOLD + 20);

        // R3: lows of exactly MIN_LOW samples are accepted
        t0 = cyc + 1;
        push(t0 + 13, 1'b0, "R3 boundary before rise");
        push(t0 + 14, 1'b1, "R3 two-sample lows accepted");
        burst(3, 2, -1, -1);
        idle(HOLD + 20);

        // R3: single-sample glitches rejected
        t0 = cyc + 1;
        push(t0 + 14, 1'b0, "R3 glitch rejected");
        push(t0 + 40, 1'b0, "R3 glitch rejected");
        push(t0 + 90, 1'b0, "R3 glitch rejected");
        push(t0 + 99, 1'b0, "R3 glitch rejected");
        burst(10, 1, -1, -1);
        idle(10);

        // R4: window boundary
        t0 = cyc + 1;
        push(t0 + WIN + 3, 1'b0, "R4 before confirm");
        push(t0 + WIN + 4, 1'b1, "R4 pulses WIN apart");
        pair(WIN);
        idle(HOLD + 20);
        t0 = cyc + 1;
        push(t0 + WIN + 5, 1'b0, "R4 pulses WIN+1 apart");
        push(t0 + WIN + 6, 1'b0, "R4 pulses WIN+1 apart");
        pair(WIN + 1);
        idle(HOLD + 20);

        // R6 / R7: loopback in the middle of activity
        t0 = cyc + 1;
        push(t0 + 14, 1'b1, "R6 flag before loopback");
        push(t0 + 29, 1'b1, "R6 flag before loopback");
        push(t0 + 30, 1'b0, "R6 loopback forces low");
        push(t0 + 45, 1'b0, "R6 loopback ignores line");
        push(t0 + 59, 1'b0, "R6 loopback ignores line");
        push(t0 + 64, 1'b0, "R7 restart needs two pulses");
        push(t0 + 73, 1'b0, "R7 restart needs two pulses");
        push(t0 + 74, 1'b1, "R7 reacquired");
        burst(12, 5, 30, 60);
        idle(HOLD + 10);

        idle(5);
        done = 1;
        if (sb.size() != 0) begin
            bad += sb.size();
            total += sb.size();
            $display("FAIL scoreboard left %0d unchecked items", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule